// File: doc/BRIEF.md
# Vector Mask Compare and Masked Subtract Unit

This block is one slice of a vector datapath. It holds a small file of vector registers, each with MVL elements of 32-bit integers, and one mask register with one bit per element. A host port writes and reads single elements. A command port starts one of three operations:
- a compare against a scalar, which writes the mask;
- an element-wise subtract, which writes a destination vector and can follow the mask;
- a clear, which sets every mask bit.

Element operations walk the vector from index 0 up to VL-1, handling one element per clock. Elements whose mask bit is 0 are skipped for writing, but they still use their clock cycle. As a result, run time depends only on VL and never on the mask contents. A `busy` level shows that an operation is running, and a `done` pulse marks its end. Software builds a mask with the compare, runs the guarded subtract, and then restores the mask with the clear.

Top module: `vmask_unit`

## Requirements
- R1: After reset `busy` and `done` are 0, every mask bit is 1 and every vector element reads as 0.
- R2: Compare (`op` = 2'b00) sets mask bit i to 1 when element i of vector `src_a` is not equal to `scalar`, and to 0 when it is equal, for every i below the effective VL.
- R3: Compare leaves mask bits at positions at or above the effective VL unchanged.
- R4: Subtract (`op` = 2'b01) writes `src_a[i] - src_b[i]`, wrapped modulo 2^32, into element i of vector `dst` for i below the effective VL when either `mask_en` is 0 or mask bit i is 1.
- R5: Subtract leaves a `dst` element unchanged when `mask_en` is 1 and its mask bit is 0, and it never changes `dst` elements at or above the effective VL.
- R6: With `mask_en` at 0, subtract updates every element below the effective VL whatever the mask holds.
- R7: An accepted compare or subtract with effective VL > 0 holds `busy` high for exactly VL cycles, starting in the cycle after `start`, whatever the mask contents. `done` is high for exactly one cycle, the first cycle with `busy` low again.
- R8: Clear (`op` = 2'b10) sets all MVL mask bits to 1. It raises `done` in the cycle after `start`, with no `busy` cycle.
- R9: A `start` seen while `busy` is high is ignored. The running operation keeps its command and finishes as if no start had come.
- R10: A `vl` above MVL is treated as MVL. A `vl` of 0 changes nothing and raises `done` in the cycle after `start` with no `busy` cycle.
- R11: `op` = 2'b11 changes no state and raises `done` in the cycle after `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launches the command on the other command inputs |
| op | input | 2 | 00 compare, 01 subtract, 10 clear mask, 11 no operation |
| vl | input | 4 | Requested vector length, clamped to MVL |
| scalar | input | 32 | Scalar operand for compare |
| src_a | input | 2 | First source vector register |
| src_b | input | 2 | Second source vector register |
| dst | input | 2 | Destination vector register for subtract |
| mask_en | input | 1 | Subtract follows the mask when 1 |
| wr_en | input | 1 | Host element write strobe |
| wr_reg | input | 2 | Host write register index |
| wr_idx | input | 3 | Host write element index |
| wr_data | input | 32 | Host write data |
| rd_reg | input | 2 | Host read register index |
| rd_idx | input | 3 | Host read element index |
| rd_data | output | 32 | Host read data, combinational |
| mask | output | 8 | Current mask register |
| busy | output | 1 | An element operation is running |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench checks that a compare with a short VL leaves the upper mask bits alone. A design that scanned the full register would clear them, because those elements equal the scalar. A masked subtract is checked on a mask with several zero bits, including one element whose difference wraps below zero. Any write to a masked-off element, or any cycle skipped for a 0 bit, shows up as a wrong element or a short busy count. A clear injected in the middle of a compare would set bits that were already written to 0, so acceptance of a start while busy changes the final mask. VL of 0, VL above MVL and the spare op code are each run to confirm a correct cycle count and untouched state.

// File: rtl/vmask_pkg.sv
package vmask_pkg;
    typedef enum logic [1:0] {
        OP_CMP = 2'b00,
        OP_SUB = 2'b01,
        OP_CLR = 2'b10,
        OP_NOP = 2'b11
    } vm_op_e;
endpackage

// File: rtl/vmask_seq.sv
module vmask_seq
    import vmask_pkg::*;
#(
    parameter int MVL       = 8,
    parameter int NUM_VREGS = 4,
    parameter int ELEM_W    = 32,
    localparam int IW  = $clog2(MVL),
    localparam int VLW = $clog2(MVL + 1),
    localparam int RW  = $clog2(NUM_VREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        op_i,
    input  logic [VLW-1:0]    vl_i,
    input  logic [ELEM_W-1:0] scalar_i,
    input  logic [RW-1:0]     ra_i,
    input  logic [RW-1:0]     rb_i,
    input  logic [RW-1:0]     rd_i,
    input  logic              men_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              elem_valid_o,
    output vm_op_e            op_o,
    output logic [IW-1:0]     idx_o,
    output logic [IW-1:0]     last_o,
    output logic [RW-1:0]     ra_o,
    output logic [RW-1:0]     rb_o,
    output logic [RW-1:0]     rd_o,
    output logic [ELEM_W-1:0] scalar_o,
    output logic              men_o,
    output logic              clr_o
);
    typedef struct packed {
        logic              busy;
        logic              done;
        vm_op_e            op;
        logic [IW-1:0]     idx;
        logic [IW-1:0]     last;
        logic [RW-1:0]     ra;
        logic [RW-1:0]     rb;
        logic [RW-1:0]     rd;
        logic [ELEM_W-1:0] scalar;
        logic              men;
    } seq_t;

    seq_t           s_d, s_q;
    logic           accept;
    logic [VLW-1:0] vl_eff;
    logic           is_elem_op;

    always_comb begin
        s_d        = s_q;
        s_d.done   = 1'b0;
        clr_o      = 1'b0;
        accept     = start_i && !s_q.busy;
        vl_eff     = (vl_i > VLW'(MVL)) ? VLW'(MVL) : vl_i;
        is_elem_op = (op_i == OP_CMP) || (op_i == OP_SUB);
        if (accept) begin
            s_d.op     = vm_op_e'(op_i);
            s_d.ra     = ra_i;
            s_d.rb     = rb_i;
            s_d.rd     = rd_i;
            s_d.scalar = scalar_i;
            s_d.men    = men_i;
            s_d.idx    = '0;
            if (is_elem_op && (vl_eff != '0)) begin
                s_d.busy = 1'b1;
                s_d.last = IW'(vl_eff - 1'b1);
            end else begin
                s_d.done = 1'b1;
                clr_o    = (op_i == OP_CLR);
            end
        end else if (s_q.busy) begin
            if (s_q.idx == s_q.last) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end else begin
                s_d.idx = s_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o       = s_q.busy;
    assign done_o       = s_q.done;
    assign elem_valid_o = s_q.busy;
    assign op_o         = s_q.op;
    assign idx_o        = s_q.idx;
    assign last_o       = s_q.last;
    assign ra_o         = s_q.ra;
    assign rb_o         = s_q.rb;
    assign rd_o         = s_q.rd;
    assign scalar_o     = s_q.scalar;
    assign men_o        = s_q.men;

    // R7: the end of a run is always flagged
    p_done_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.busy) |-> s_q.done);
    // R7: done and busy never overlap
    p_done_not_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |-> !s_q.busy);
    // R10: element index never passes the clamped length
    p_idx_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> (s_q.idx <= s_q.last));
    // R9: a start during a run leaves the captured command alone
    p_ignore_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && start_i) |=> ($stable(s_q.op) && $stable(s_q.rd) && $stable(s_q.last)));
endmodule

// File: rtl/vmask_alu.sv
module vmask_alu
    import vmask_pkg::*;
#(
    parameter int ELEM_W = 32
) (
    input  vm_op_e            op_i,
    input  logic              valid_i,
    input  logic [ELEM_W-1:0] a_i,
    input  logic [ELEM_W-1:0] b_i,
    input  logic [ELEM_W-1:0] scalar_i,
    input  logic              mask_bit_i,
    input  logic              men_i,
    output logic              vec_we_o,
    output logic [ELEM_W-1:0] vec_wdata_o,
    output logic              mask_we_o,
    output logic              mask_wbit_o
);
    always_comb begin
        vec_we_o    = 1'b0;
        vec_wdata_o = a_i - b_i;
        mask_we_o   = 1'b0;
        mask_wbit_o = (a_i != scalar_i);
        if (valid_i) begin
            case (op_i)
                OP_CMP:  mask_we_o = 1'b1;
                OP_SUB:  vec_we_o  = !men_i || mask_bit_i;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/vmask_vrf.sv
module vmask_vrf #(
    parameter int MVL       = 8,
    parameter int NUM_VREGS = 4,
    parameter int ELEM_W    = 32,
    localparam int IW = $clog2(MVL),
    localparam int RW = $clog2(NUM_VREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [RW-1:0]     host_wreg,
    input  logic [IW-1:0]     host_widx,
    input  logic [ELEM_W-1:0] host_wdata,
    input  logic [RW-1:0]     host_rreg,
    input  logic [IW-1:0]     host_ridx,
    output logic [ELEM_W-1:0] host_rdata,
    input  logic [RW-1:0]     eng_ra,
    input  logic [RW-1:0]     eng_rb,
    input  logic [RW-1:0]     eng_rd,
    input  logic [IW-1:0]     eng_idx,
    output logic [ELEM_W-1:0] eng_a,
    output logic [ELEM_W-1:0] eng_b,
    output logic              eng_mask_bit,
    input  logic              eng_vec_we,
    input  logic [ELEM_W-1:0] eng_vec_wdata,
    input  logic              eng_mask_we,
    input  logic              eng_mask_wbit,
    input  logic              mask_set_all,
    output logic [MVL-1:0]    mask_o
);
    logic [ELEM_W-1:0] vreg_d [NUM_VREGS][MVL];
    logic [ELEM_W-1:0] vreg_q [NUM_VREGS][MVL];
    logic [MVL-1:0]    mask_d, mask_q;

    always_comb begin
        vreg_d = vreg_q;
        mask_d = mask_q;
        if (host_we)      vreg_d[host_wreg][host_widx] = host_wdata;
        if (eng_vec_we)   vreg_d[eng_rd][eng_idx]      = eng_vec_wdata;
        if (eng_mask_we)  mask_d[eng_idx]              = eng_mask_wbit;
        if (mask_set_all) mask_d                       = '1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_VREGS; r++) begin
                for (int e = 0; e < MVL; e++) begin
                    vreg_q[r][e] <= '0;
                end
            end
            mask_q <= '1;
        end else begin
            vreg_q <= vreg_d;
            mask_q <= mask_d;
        end
    end

    assign host_rdata   = vreg_q[host_rreg][host_ridx];
    assign eng_a        = vreg_q[eng_ra][eng_idx];
    assign eng_b        = vreg_q[eng_rb][eng_idx];
    assign eng_mask_bit = mask_q[eng_idx];
    assign mask_o       = mask_q;

    // R8: a clear request leaves every mask bit set
    p_clear_all_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mask_set_all |=> (mask_q == '1));
endmodule

// File: rtl/vmask_unit.sv
module vmask_unit
    import vmask_pkg::*;
#(
    parameter int MVL       = 8,
    parameter int NUM_VREGS = 4,
    parameter int ELEM_W    = 32,
    localparam int IW  = $clog2(MVL),
    localparam int VLW = $clog2(MVL + 1),
    localparam int RW  = $clog2(NUM_VREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [VLW-1:0]    vl,
    input  logic [ELEM_W-1:0] scalar,
    input  logic [RW-1:0]     src_a,
    input  logic [RW-1:0]     src_b,
    input  logic [RW-1:0]     dst,
    input  logic              mask_en,
    input  logic              wr_en,
    input  logic [RW-1:0]     wr_reg,
    input  logic [IW-1:0]     wr_idx,
    input  logic [ELEM_W-1:0] wr_data,
    input  logic [RW-1:0]     rd_reg,
    input  logic [IW-1:0]     rd_idx,
    output logic [ELEM_W-1:0] rd_data,
    output logic [MVL-1:0]    mask,
    output logic              busy,
    output logic              done
);
    logic              elem_valid, men_q, clr_now;
    vm_op_e            op_q;
    logic [IW-1:0]     idx_q, last_q;
    logic [RW-1:0]     ra_q, rb_q, rd_q;
    logic [ELEM_W-1:0] scalar_q, a_elem, b_elem, vec_wdata;
    logic              mask_bit, vec_we, mask_we, mask_wbit;

    vmask_seq #(.MVL(MVL), .NUM_VREGS(NUM_VREGS), .ELEM_W(ELEM_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .vl_i(vl),
        .scalar_i(scalar), .ra_i(src_a), .rb_i(src_b), .rd_i(dst), .men_i(mask_en),
        .busy_o(busy), .done_o(done), .elem_valid_o(elem_valid), .op_o(op_q),
        .idx_o(idx_q), .last_o(last_q), .ra_o(ra_q), .rb_o(rb_q), .rd_o(rd_q),
        .scalar_o(scalar_q), .men_o(men_q), .clr_o(clr_now)
    );

    vmask_alu #(.ELEM_W(ELEM_W)) u_alu (
        .op_i(op_q), .valid_i(elem_valid), .a_i(a_elem), .b_i(b_elem),
        .scalar_i(scalar_q), .mask_bit_i(mask_bit), .men_i(men_q),
        .vec_we_o(vec_we), .vec_wdata_o(vec_wdata),
        .mask_we_o(mask_we), .mask_wbit_o(mask_wbit)
    );

    vmask_vrf #(.MVL(MVL), .NUM_VREGS(NUM_VREGS), .ELEM_W(ELEM_W)) u_vrf (
        .clk(clk), .rst_n(rst_n),
        .host_we(wr_en), .host_wreg(wr_reg), .host_widx(wr_idx), .host_wdata(wr_data),
        .host_rreg(rd_reg), .host_ridx(rd_idx), .host_rdata(rd_data),
        .eng_ra(ra_q), .eng_rb(rb_q), .eng_rd(rd_q), .eng_idx(idx_q),
        .eng_a(a_elem), .eng_b(b_elem), .eng_mask_bit(mask_bit),
        .eng_vec_we(vec_we), .eng_vec_wdata(vec_wdata),
        .eng_mask_we(mask_we), .eng_mask_wbit(mask_wbit),
        .mask_set_all(clr_now), .mask_o(mask)
    );

    // R5: a masked-off element is never written
    p_masked_off_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_valid && op_q == OP_SUB && men_q && !mask_bit) |-> !vec_we);
    // R2: compare touches only the mask
    p_cmp_mask_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_valid && op_q == OP_CMP) |-> (mask_we && !vec_we));
    // R6: unmasked subtract writes every active element
    p_unmasked_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_valid && op_q == OP_SUB && !men_q) |-> vec_we);

    for (genvar e = 0; e < MVL; e++) begin : g_upper
        // R3: bits above the vector length survive a compare
        p_mask_above_vl_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (elem_valid && op_q == OP_CMP && (IW'(e) > last_q)) |=> $stable(mask[e]));
    end
endmodule

// File: tb/vmask_unit_tb.sv
`timescale 1ns/1ps
module vmask_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [3:0]  vl = '0;
    logic [31:0] scalar = '0;
    logic [1:0]  src_a = '0, src_b = '0, dst = '0;
    logic        mask_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_reg = '0;
    logic [2:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_reg = '0;
    logic [2:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic [7:0]  mask;
    logic        busy, done;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] ev [4][8];
    logic [7:0]  em;

    always #2 clk = ~clk;

    vmask_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .vl(vl), .scalar(scalar),
        .src_a(src_a), .src_b(src_b), .dst(dst), .mask_en(mask_en),
        .wr_en(wr_en), .wr_reg(wr_reg), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_reg(rd_reg), .rd_idx(rd_idx), .rd_data(rd_data),
        .mask(mask), .busy(busy), .done(done)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic load_vec(input int r, input logic [31:0] d [8]);
        for (int e = 0; e < 8; e++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_reg = 2'(r); wr_idx = 3'(e); wr_data = d[e];
            ev[r][e] = d[e];
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic chk_vec(input string req, input int r);
        for (int e = 0; e < 8; e++) begin
            rd_reg = 2'(r); rd_idx = 3'(e);
            #0.5;
            chk(req, $sformatf("v%0d[%0d]", r, e), rd_data, ev[r][e]);
        end
    endtask

    task automatic run_op(input string req, input logic [1:0] o, input logic [3:0] len,
                          input logic [31:0] s, input int ra, input int rb, input int rd,
                          input logic men, input int exp_cycles, input logic poke);
        int cnt;
        @(negedge clk);
        op = o; vl = len; scalar = s; src_a = 2'(ra); src_b = 2'(rb); dst = 2'(rd);
        mask_en = men; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 0;
        while (busy && cnt < 64) begin
            if (poke && cnt == 2) begin
                start = 1'b1; op = 2'b10; vl = 4'd8;
            end else begin
                start = 1'b0;
            end
            cnt++;
            @(negedge clk);
        end
        start = 1'b0;
        chk(req, "busy cycles", 32'(cnt), 32'(exp_cycles));
        chk(req, "done at end", 32'(done), 32'd1);
        @(negedge clk);
        chk(req, "done one cycle", 32'(done), 32'd0);
    endtask

    task automatic t_reset();
        chk("R1", "busy", 32'(busy), 32'd0);
        chk("R1", "done", 32'(done), 32'd0);
        chk("R1", "mask", 32'(mask), 32'hff);
        chk_vec("R1", 2);
    endtask

    task automatic t_cmp_full();
        logic [31:0] d [8] = '{32'd5, 32'd0, 32'd5, 32'd7, 32'd5, 32'hffffffff, 32'd1, 32'd5};
        load_vec(0, d);
        for (int e = 0; e < 8; e++) em[e] = (ev[0][e] != 32'd5);
        run_op("R7", 2'b00, 4'd8, 32'd5, 0, 0, 0, 1'b0, 8, 1'b0);
        chk("R2", "mask after compare", 32'(mask), 32'(em));
    endtask

    task automatic t_sub_masked();
        logic [31:0] b [8] = '{32'd1, 32'd2, 32'd3, 32'd4, 32'd5, 32'd6, 32'd7, 32'd8};
        logic [31:0] c [8];
        for (int e = 0; e < 8; e++) c[e] = 32'haaaa0000 + 32'(e);
        load_vec(1, b);
        load_vec(2, c);
        for (int e = 0; e < 8; e++) if (em[e]) ev[2][e] = ev[0][e] - ev[1][e];
        run_op("R7", 2'b01, 4'd8, 32'd0, 0, 1, 2, 1'b1, 8, 1'b0);
        chk_vec("R4", 2);
        chk_vec("R5", 2);
    endtask

    task automatic t_clear();
        run_op("R8", 2'b10, 4'd3, 32'd0, 0, 0, 0, 1'b0, 0, 1'b0);
        em = 8'hff;
        chk("R8", "mask after clear", 32'(mask), 32'(em));
    endtask

    task automatic t_cmp_short();
        logic [31:0] d [8] = '{32'd5, 32'd5, 32'd5, 32'd5, 32'd5, 32'd5, 32'd5, 32'd5};
        load_vec(3, d);
        em = 8'hf8;
        run_op("R3", 2'b00, 4'd3, 32'd5, 3, 0, 0, 1'b0, 3, 1'b0);
        chk("R3", "upper mask bits kept", 32'(mask), 32'(em));
    endtask

    task automatic t_sub_unmasked();
        for (int e = 0; e < 5; e++) ev[3][e] = ev[0][e] - ev[1][e];
        run_op("R6", 2'b01, 4'd5, 32'd0, 0, 1, 3, 1'b0, 5, 1'b0);
        chk_vec("R6", 3);
        chk("R5", "v3[7] above VL", ev[3][7], 32'd5);
        chk("R6", "mask untouched", 32'(mask), 32'(em));
    endtask

    task automatic t_busy_start();
        for (int e = 0; e < 8; e++) em[e] = (ev[1][e] != 32'd1);
        run_op("R9", 2'b00, 4'd8, 32'd1, 1, 0, 0, 1'b0, 8, 1'b1);
        chk("R9", "mask with ignored clear", 32'(mask), 32'(em));
    endtask

    task automatic t_vl_edges();
        run_op("R10", 2'b01, 4'd0, 32'd0, 0, 1, 2, 1'b0, 0, 1'b0);
        chk_vec("R10", 2);
        for (int e = 0; e < 8; e++) em[e] = (ev[1][e] != 32'd3);
        run_op("R10", 2'b00, 4'd15, 32'd3, 1, 0, 0, 1'b0, 8, 1'b0);
        chk("R10", "mask with clamped VL", 32'(mask), 32'(em));
    endtask

    task automatic t_reserved();
        run_op("R11", 2'b11, 4'd8, 32'd0, 0, 1, 2, 1'b0, 0, 1'b0);
        chk("R11", "mask unchanged", 32'(mask), 32'(em));
        chk_vec("R11", 2);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL R7 watchdog: actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int r = 0; r < 4; r++) for (int e = 0; e < 8; e++) ev[r][e] = '0;
        em = 8'hff;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_cmp_full();
        t_sub_masked();
        t_clear();
        t_cmp_short();
        t_sub_unmasked();
        t_busy_start();
        t_vl_edges();
        t_reserved();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule